// File: doc/BRIEF.md
# Shadow RAM segment access decoder

This block sits beside the memory controller and decides, for every access into the legacy upper-memory window, whether the access is served from internal memory (shadow RAM) or passed to the external bus. Reads and writes are decided on their own, so firmware can copy a ROM image into shadow RAM while reads still go to the ROM, and then flip reads to the internal copy and leave writes on the external bus.

The window covers 0xC0000 to 0xFFFFF. The lower part, 0xC0000 to 0xEFFFF, is split into twelve 16 KB segments. The top 64 KB, starting at 0xF0000, is one segment. Four control bytes hold the enables. They are loaded one byte at a time through a synchronous write port addressed by an 8-bit register index in the range 0x44 to 0x47. The decode is combinational: the two flags follow the address, the direction input and the stored bytes with no added cycle.

Top module: `shadow_window_decoder`

## Requirements
- R1: After a synchronous reset every control byte is zero, so both flags stay low for every address and direction.
- R2: Segment i (0 to 11) covers 0xC0000 + i*0x4000 up to 0xC0000 + i*0x4000 + 0x3FFF. Its control byte is register index 0x44 + ((i >> 2) XOR 3): segments 0-3 use 0x47, segments 4-7 use 0x46 and segments 8-11 use 0x45.
- R3: Within that byte, bit (i & 3) enables internal writes for segment i and bit (i & 3) + 4 enables internal reads. A clear bit sends that direction to the external bus.
- R4: The 64 KB segment at 0xF0000-0xFFFFF uses index 0x44: bit 0 enables internal writes and bit 1 enables internal reads.
- R5: A write to index 0x44 stores only the bits under mask 0xCB and does not change the decision for any of the twelve 16 KB segments.
- R6: A write to any index other than 0x44-0x47 changes no decision.
- R7: An address below 0xC0000 or at or above 0x100000 drives both flags low, whatever the control bytes hold.
- R8: rd_internal can be high only while acc_is_write is 0, and wr_internal only while acc_is_write is 1.
- R9: The flags are a combinational function of the address, the direction and the stored bytes: a change of address or direction shows on the flags in the same cycle.
- R10: A control write takes effect at the rising clock edge on which cfg_we is sampled high; before that edge the old decision holds, and with cfg_we low the bytes never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_idx | input | 8 | Register index of the control byte written |
| cfg_wdata | input | 8 | Data for the control byte |
| acc_addr | input | 32 | Byte address of the access being decided |
| acc_is_write | input | 1 | 1 for a write access, 0 for a read |
| rd_internal | output | 1 | Read is served from internal memory |
| wr_internal | output | 1 | Write is served to internal memory |

## Verification
The hardest thing to reach from the ports is proof that each enable bit lands on exactly one segment and one direction, since the reversed byte order and split bit lanes make a wrong mapping look right for most addresses. The bench walks a single set bit through all twelve segments and checks the segment itself and both neighbours at their first and last byte, in both directions. Random control writes, including writes to indices near but outside the control range, are then mixed with random addresses drawn from the window edges and its interior and compared with a model built from the requirements. The ordering of a write against the clock edge is checked by sampling the flags just before and just after the edge that loads the byte.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  localparam int CTL_BYTES = 4;
  localparam int CTL_W     = 8;
  localparam logic [7:0] CTL_BASE_IDX = 8'h44;
  localparam logic [7:0] TOP_KEEP_MASK = 8'hCB;
  localparam int LANE_W = CTL_W / 2;

  typedef logic [CTL_W-1:0] ctl_byte_t;
  typedef ctl_byte_t [CTL_BYTES-1:0] ctl_bank_t;

  // Byte slot (offset from CTL_BASE_IDX) holding the enables of segment i:
  // the first group of four segments lives in the highest slot.
  function automatic int seg_slot(input int i);
    return (i / LANE_W) ^ (CTL_BYTES - 1);
  endfunction

  function automatic int seg_wr_bit(input int i);
    return i % LANE_W;
  endfunction

  function automatic int seg_rd_bit(input int i);
    return (i % LANE_W) + LANE_W;
  endfunction
endpackage

// File: rtl/shadow_ctl_regs.sv
module shadow_ctl_regs
  import shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output ctl_bank_t   ctl_q
);
  logic [7:0] offs;
  logic       hit;

  assign offs = idx - CTL_BASE_IDX;
  assign hit  = offs < 8'(CTL_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (we && hit) begin
      if (offs[1:0] == 2'd0)
        ctl_q[0] <= wdata & TOP_KEEP_MASK;
      else
        ctl_q[offs[1:0]] <= wdata;
    end
  end

  // R1: bank is clear in the first cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctl_q == '0));

  // R10: with no write strobe the bank holds
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(we)) |-> $stable(ctl_q));

  // R10: a full-width slot is loaded on the sampling edge
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    (we && idx == CTL_BASE_IDX + 8'd3) |=> (ctl_q[3] == $past(wdata)));
endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup #(
  parameter int ADDR_W    = 32,
  parameter int SEG_COUNT = 12,
  parameter int SEG_SHIFT = 14,
  parameter int TOP_SHIFT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  output logic [SEG_COUNT-1:0] seg_hit,
  output logic                 top_hit
);
  localparam logic [ADDR_W-1:0] SEG_SPAN = ADDR_W'(1) << SEG_SHIFT;
  localparam logic [ADDR_W-1:0] TOP_SPAN = ADDR_W'(1) << TOP_SHIFT;
  localparam logic [ADDR_W-1:0] TOP_BASE = WIN_BASE + ADDR_W'(SEG_COUNT) * SEG_SPAN;
  localparam logic [ADDR_W-1:0] TOP_END  = TOP_BASE + TOP_SPAN;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    localparam logic [ADDR_W-1:0] LO = WIN_BASE + ADDR_W'(i) * SEG_SPAN;
    localparam logic [ADDR_W-1:0] HI = LO + SEG_SPAN;
    assign seg_hit[i] = (addr >= LO) && (addr < HI);
  end

  assign top_hit = (addr >= TOP_BASE) && (addr < TOP_END);

  // R2: at most one region claims an address
  p_hit_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seg_hit, top_hit}));
endmodule

// File: rtl/shadow_seg_policy.sv
module shadow_seg_policy
  import shadow_pkg::*;
#(
  parameter int SEG_COUNT = 12
) (
  input  ctl_bank_t            ctl,
  input  logic [SEG_COUNT-1:0] seg_hit,
  input  logic                 top_hit,
  output logic                 rd_en,
  output logic                 wr_en
);
  logic [SEG_COUNT-1:0] rd_vec;
  logic [SEG_COUNT-1:0] wr_vec;

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_lane
    localparam int SLOT = seg_slot(i);
    localparam int WB   = seg_wr_bit(i);
    localparam int RB   = seg_rd_bit(i);
    assign wr_vec[i] = seg_hit[i] & ctl[SLOT][WB];
    assign rd_vec[i] = seg_hit[i] & ctl[SLOT][RB];
  end

  assign wr_en = (|wr_vec) | (top_hit & ctl[0][0]);
  assign rd_en = (|rd_vec) | (top_hit & ctl[0][1]);
endmodule

// File: rtl/shadow_window_decoder.sv
module shadow_window_decoder
  import shadow_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_COUNT = 12,
  parameter int SEG_SHIFT = 14,
  parameter int TOP_SHIFT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_idx,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_write,
  output logic              rd_internal,
  output logic              wr_internal
);
  ctl_bank_t            ctl_q;
  logic [SEG_COUNT-1:0] seg_hit;
  logic                 top_hit;
  logic                 rd_en;
  logic                 wr_en;

  shadow_ctl_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (cfg_wdata),
    .ctl_q (ctl_q)
  );

  shadow_seg_lookup #(
    .ADDR_W    (ADDR_W),
    .SEG_COUNT (SEG_COUNT),
    .SEG_SHIFT (SEG_SHIFT),
    .TOP_SHIFT (TOP_SHIFT),
    .WIN_BASE  (WIN_BASE)
  ) u_lookup (
    .clk     (clk),
    .rst     (rst),
    .addr    (acc_addr),
    .seg_hit (seg_hit),
    .top_hit (top_hit)
  );

  shadow_seg_policy #(
    .SEG_COUNT (SEG_COUNT)
  ) u_policy (
    .ctl     (ctl_q),
    .seg_hit (seg_hit),
    .top_hit (top_hit),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  assign rd_internal = rd_en & ~acc_is_write;
  assign wr_internal = wr_en &  acc_is_write;

  // R7: nothing outside the window is served internally
  p_outside_r7: assert property (@(posedge clk) disable iff (rst)
    !(|seg_hit || top_hit) |-> (!rd_internal && !wr_internal));

  // R8: each flag only for its own direction
  p_dir_rd_r8: assert property (@(posedge clk) disable iff (rst)
    acc_is_write |-> !rd_internal);
  p_dir_wr_r8: assert property (@(posedge clk) disable iff (rst)
    !acc_is_write |-> !wr_internal);

  // R5: bits outside the keep mask are never held in the top byte
  p_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] & ~TOP_KEEP_MASK) == 8'h00);
endmodule

// File: tb/shadow_window_decoder_tb.sv
`timescale 1ns/1ps
module shadow_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic [31:0] acc_addr;
  logic        acc_is_write;
  logic        rd_internal;
  logic        wr_internal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mdl [4];

  always #10 clk = ~clk;

  shadow_window_decoder u_dut (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_wdata    (cfg_wdata),
    .acc_addr     (acc_addr),
    .acc_is_write (acc_is_write),
    .rd_internal  (rd_internal),
    .wr_internal  (wr_internal)
  );

  // Expected {rd, wr} from the requirements
  function automatic logic [1:0] expect_flags(input logic [31:0] a, input logic w);
    logic rdv, wrv;
    rdv = 1'b0; wrv = 1'b0;
    if (a >= 32'h000C_0000 && a < 32'h000F_0000) begin
      int seg, slot;
      logic [7:0] b;
      seg  = int'((a - 32'h000C_0000) >> 14);
      slot = (seg >> 2) ^ 3;
      b    = mdl[slot];
      wrv  = b[seg & 3];
      rdv  = b[(seg & 3) + 4];
    end else if (a >= 32'h000F_0000 && a < 32'h0010_0000) begin
      wrv = mdl[0][0];
      rdv = mdl[0][1];
    end
    return {rdv & ~w, wrv & w};
  endfunction

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 8'h44) mdl[0] = d & 8'hCB;
    else if (idx >= 8'h45 && idx <= 8'h47) mdl[idx - 8'h44] = d;
  endtask

  task automatic probe(input logic [31:0] a, input logic w, input string req);
    logic [1:0] e;
    acc_addr = a; acc_is_write = w;
    #1;
    e = expect_flags(a, w);
    checks++;
    if ({rd_internal, wr_internal} !== e) begin
      fails++;
      $display("FAIL %s addr=%h wr=%0b actual rd/wr=%b%b expected=%b",
               req, a, w, rd_internal, wr_internal, e);
    end
  endtask

  task automatic probe_both(input logic [31:0] a, input string req);
    probe(a, 1'b0, req);
    probe(a, 1'b1, req);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) cfg_write(8'h44 + 8'(k), 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C00));
    for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
    rst = 1'b1; cfg_we = 1'b0; cfg_idx = 8'h00; cfg_wdata = 8'h00;
    acc_addr = 32'h0; acc_is_write = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: everything external after reset
    probe_both(32'h000C_0000, "R1");
    probe_both(32'h000E_7FFF, "R1");
    probe_both(32'h000F_8000, "R1");

    // R2 R3: walk each segment's write and read bit
    for (int i = 0; i < 12; i++) begin
      logic [31:0] lo;
      lo = 32'h000C_0000 + 32'(i) * 32'h4000;
      for (int lane = 0; lane < 2; lane++) begin
        clear_all();
        cfg_write(8'h44 + 8'(((i >> 2) ^ 3)), 8'(1 << ((i & 3) + 4 * lane)));
        probe_both(lo, "R3");
        probe_both(lo + 32'h3FFF, "R2");
        probe_both(lo - 32'h1, "R2");
        probe_both(lo + 32'h4000, "R2");
      end
    end

    // R4: top segment bits
    clear_all();
    cfg_write(8'h44, 8'h01);
    probe_both(32'h000F_0000, "R4");
    probe_both(32'h000F_FFFF, "R4");
    cfg_write(8'h44, 8'h02);
    probe_both(32'h000F_0000, "R4");
    probe_both(32'h000E_FFFF, "R4");

    // R5: top byte write leaves the 16 KB segments alone
    cfg_write(8'h45, 8'h5A);
    cfg_write(8'h46, 8'hA5);
    cfg_write(8'h47, 8'h3C);
    cfg_write(8'h44, 8'hFF);
    for (int i = 0; i < 12; i++)
      probe_both(32'h000C_0000 + 32'(i) * 32'h4000 + 32'h100, "R5");
    probe_both(32'h000F_1234, "R5");

    // R6: out-of-range indices do nothing
    clear_all();
    cfg_write(8'h43, 8'hFF);
    cfg_write(8'h48, 8'hFF);
    cfg_write(8'hC4, 8'hFF);
    cfg_write(8'h04, 8'hFF);
    probe_both(32'h000C_0000, "R6");
    probe_both(32'h000D_0000, "R6");
    probe_both(32'h000E_C000, "R6");
    probe_both(32'h000F_0000, "R6");

    // R7: outside the window with everything enabled
    for (int k = 0; k < 4; k++) cfg_write(8'h44 + 8'(k), 8'hFF);
    probe_both(32'h000B_FFFF, "R7");
    probe_both(32'h0010_0000, "R7");
    probe_both(32'h0000_0000, "R7");
    probe_both(32'hFFFF_FFFF, "R7");
    probe_both(32'h001C_0000, "R7");

    // R8: direction qualifies each flag
    probe(32'h000D_4000, 1'b0, "R8");
    probe(32'h000D_4000, 1'b1, "R8");

    // R9: same-cycle response to address and direction changes
    cfg_write(8'h46, 8'h0F);
    @(negedge clk);
    probe(32'h000D_0000, 1'b1, "R9");
    probe(32'h000D_0000, 1'b0, "R9");
    probe(32'h000C_0000, 1'b0, "R9");

    // R10: write visible only after the sampling edge
    clear_all();
    acc_addr = 32'h000C_8000; acc_is_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'h47; cfg_wdata = 8'h40;
    #5; probe(32'h000C_8000, 1'b0, "R10");
    @(posedge clk); #1;
    cfg_we = 1'b0;
    mdl[3] = 8'h40;
    probe(32'h000C_8000, 1'b0, "R10");
    checks++;
    if (rd_internal !== 1'b1) begin
      fails++;
      $display("FAIL R10 read flag after load actual=%b expected=1", rd_internal);
    end

    // Random mix against the model
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 3) == 0)
        cfg_write(8'h42 + 8'($urandom % 8), 8'($urandom));
      else begin
        logic [31:0] a;
        case ($urandom % 4)
          0: a = 32'h000C_0000 + ($urandom % 32'h40000);
          1: a = 32'h000C_0000 + 32'($urandom % 13) * 32'h4000 - 32'($urandom % 2);
          2: a = 32'h000B_F000 + ($urandom % 32'h2000);
          default: a = 32'h000F_F000 + ($urandom % 32'h2000);
        endcase
        probe(a, 1'($urandom), "R2 R3 R4 R7 random");
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule